// File: doc/BRIEF.md
# Masked-Write GPIO Bank

This block is one 32-pin general-purpose I/O bank behind a plain 32-bit register bus. Software sets each pin's direction and its output enable, and drives output levels. It reads back the pin levels through a synchroniser. The pad side is three separate vectors: output level, output enable and input level.

The output data can be changed in two ways. A full-word register replaces all 32 output bits in one write. Two write-only half-word ports each carry a 16-bit protect mask in the upper half and 16 data bits in the lower half. Only the bits whose protect bit is 0 take the new data. This lets several software agents update their own pins without a read-modify-write sequence. The bus has one write strobe. Read data is combinational from the address, and every write takes effect on the clock edge that samples the strobe.

Top module: `gpio_mw_bank`

## Requirements
- R1: While reset is asserted (synchronous, active low), the output data, direction and output-enable registers clear to zero, so `pad_oe` and `pad_out` are all zeros one edge later.
- R2: A write to offset 0x000 updates output bits 15:0. For each i in 0..15, bit i takes `wdata[i]` when `wdata[16+i]` is 0 and keeps its value when `wdata[16+i]` is 1. Bits 31:16 do not change.
- R3: A write to offset 0x004 updates output bits 31:16. For each i in 0..15, bit 16+i takes `wdata[i]` when `wdata[16+i]` is 0 and keeps its value when `wdata[16+i]` is 1. Bits 15:0 do not change.
- R4: A write to offset 0x040 replaces all 32 output data bits. A read of offset 0x040 returns the output data register.
- R5: A read of offset 0x060 returns `pad_in` as sampled through two flops. A change of `pad_in` shows on the read after the second rising edge and not after the first.
- R6: Offset 0x204 is the read/write direction register (1 = output). Offset 0x208 is the read/write output-enable register.
- R7: `pad_oe[i]` is 1 only when direction bit i and output-enable bit i are both 1. `pad_out[i]` equals output data bit i when `pad_oe[i]` is 1 and is 0 otherwise.
- R8: Reads of 0x000, 0x004 and of any unmapped offset return zero. Writes to 0x060 or to any unmapped offset (any offset other than 0x000, 0x004, 0x040, 0x204, 0x208, including misaligned ones) change no register.
- R9: A read of the offset being written in the same cycle returns the value held before that write. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Pin levels from the pads, asynchronous |
| pad_out | output | 32 | Output level to the pads |
| pad_oe | output | 32 | Per-pin drive enable to the pads |

## Verification
A write and a read of the same register share a cycle. The bus presents one address, and read data is combinational from that address. So every write in the bench first samples `bus_rdata` in the write cycle itself, before the edge, and judges it against the bench model's value from before the write. It then reads the register again in the following cycle and expects the merged result. Random masked writes with mixed protect patterns are interleaved with full-word, direction and output-enable writes. The protect and data fields therefore land on bits whose current value differs from the data. Both the kept bits and the taken bits are compared against the model after each write.

// File: rtl/gpio_mw_pkg.sv
// Package: shared offsets, decoded register targets and the offset decoder
// for the masked-write GPIO bank. Assumes byte offsets, word-aligned registers.
package gpio_mw_pkg;

    localparam logic [31:0] OFF_MW_LO = 32'h0000_0000;
    localparam logic [31:0] OFF_MW_HI = 32'h0000_0004;
    localparam logic [31:0] OFF_DATA  = 32'h0000_0040;
    localparam logic [31:0] OFF_PINS  = 32'h0000_0060;
    localparam logic [31:0] OFF_DIR   = 32'h0000_0204;
    localparam logic [31:0] OFF_OE    = 32'h0000_0208;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_MW_LO,
        TGT_MW_HI,
        TGT_DATA,
        TGT_PINS,
        TGT_DIR,
        TGT_OE
    } tgt_e;

    // Maps a byte offset to its register target; anything else is TGT_NONE.
    function automatic tgt_e decode_offset(input logic [31:0] off);
        tgt_e t;
        case (off)
            OFF_MW_LO: t = TGT_MW_LO;
            OFF_MW_HI: t = TGT_MW_HI;
            OFF_DATA:  t = TGT_DATA;
            OFF_PINS:  t = TGT_PINS;
            OFF_DIR:   t = TGT_DIR;
            OFF_OE:    t = TGT_OE;
            default:   t = TGT_NONE;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/gpio_mw_sync.sv
// Two-flop input synchroniser for the pad input vector.
// Assumes each bit is sampled independently; no reset on the flops, since
// their contents are flushed by the live input within two edges.
module gpio_mw_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Shift the asynchronous inputs through two capture stages.
    always_ff @(posedge clk) begin
        stage1 <= d;
        stage2 <= stage1;
    end

    assign q = stage2;

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        q == $past(d, 2)) else $error("sync depth broken"); // R5

endmodule

// File: rtl/gpio_mw_regs.sv
// Register file: output data, direction and output enable, with the two
// half-word masked-write ports merged into the output data register.
// Assumes DATA_W is even; the protect mask sits in the upper half of wdata.
module gpio_mw_regs
    import gpio_mw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  tgt_e              wr_tgt,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] dir_q,
    output logic [DATA_W-1:0] oe_q
);

    localparam int HALF = DATA_W / 2;

    logic [HALF-1:0]   protect;
    logic [HALF-1:0]   value;
    logic [HALF-1:0]   merged [2];
    logic [DATA_W-1:0] data_d;

    assign protect = wdata[DATA_W-1:HALF];
    assign value   = wdata[HALF-1:0];

    // Per half: keep protected bits, take data on unprotected bits.
    for (genvar h = 0; h < 2; h++) begin : g_half
        assign merged[h] = (data_q[h*HALF +: HALF] & protect) | (value & ~protect);
    end

    // Next output data from whichever write port is addressed.
    always_comb begin
        data_d = data_q;
        if (wr_en) begin
            case (wr_tgt)
                TGT_MW_LO: data_d[HALF-1:0]      = merged[0];
                TGT_MW_HI: data_d[DATA_W-1:HALF] = merged[1];
                TGT_DATA:  data_d                = wdata;
                default:   data_d                = data_q;
            endcase
        end
    end

    // Output data register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    // Direction and output-enable registers, written as full words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            oe_q  <= '0;
        end else if (wr_en) begin
            if (wr_tgt == TGT_DIR) dir_q <= wdata;
            if (wr_tgt == TGT_OE)  oe_q  <= wdata;
        end
    end

    AST_LO_PROTECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_tgt == TGT_MW_LO) |=>
        (((data_q[HALF-1:0] ^ $past(data_q[HALF-1:0])) & $past(wdata[DATA_W-1:HALF])) == '0
         && data_q[DATA_W-1:HALF] == $past(data_q[DATA_W-1:HALF])))
        else $error("low masked write touched a protected bit"); // R2

    AST_HI_PROTECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_tgt == TGT_MW_HI) |=>
        (((data_q[DATA_W-1:HALF] ^ $past(data_q[DATA_W-1:HALF])) & $past(wdata[DATA_W-1:HALF])) == '0
         && data_q[HALF-1:0] == $past(data_q[HALF-1:0])))
        else $error("high masked write touched a protected bit"); // R3

    AST_DEAD_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_tgt == TGT_NONE || wr_tgt == TGT_PINS)) |=>
        ($stable(data_q) && $stable(dir_q) && $stable(oe_q)))
        else $error("ignored write changed state"); // R8

endmodule

// File: rtl/gpio_mw_pad.sv
// Pad drive gating: a pin drives only when both its direction and its
// output-enable bits are set; the level is forced low when not driving.
module gpio_mw_pad #(
    parameter int W = 32
) (
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] oe_q,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);

    // Combine direction and enable, then gate the level with the result.
    always_comb begin
        pad_oe  = dir_q & oe_q;
        pad_out = data_q & pad_oe;
    end

endmodule

// File: rtl/gpio_mw_bank.sv
// Top: one 32-pin GPIO bank with masked half-word writes. Decodes the bus
// offset, holds the registers, synchronises the pad inputs and drives the
// combinational read mux. Assumes one access per cycle on the bus.
module gpio_mw_bank
    import gpio_mw_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pad_in,
    output logic [DATA_W-1:0] pad_out,
    output logic [DATA_W-1:0] pad_oe
);

    tgt_e              tgt;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] dir_q;
    logic [DATA_W-1:0] oe_q;
    logic [DATA_W-1:0] pins_sync;

    assign tgt = decode_offset(32'(bus_addr));

    gpio_mw_sync #(.W(DATA_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pins_sync)
    );

    gpio_mw_regs #(.DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .wr_tgt (tgt),
        .wdata  (bus_wdata),
        .data_q (data_q),
        .dir_q  (dir_q),
        .oe_q   (oe_q)
    );

    gpio_mw_pad #(.W(DATA_W)) u_pad (
        .data_q  (data_q),
        .dir_q   (dir_q),
        .oe_q    (oe_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    // Read mux: readable registers by offset, zero for everything else.
    always_comb begin
        case (tgt)
            TGT_DATA: bus_rdata = data_q;
            TGT_PINS: bus_rdata = pins_sync;
            TGT_DIR:  bus_rdata = dir_q;
            TGT_OE:   bus_rdata = oe_q;
            default:  bus_rdata = '0;
        endcase
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_out == '0))
        else $error("pads active after reset"); // R1

    AST_NO_DRIVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0)
        else $error("level on an undriven pin"); // R7

endmodule

// File: tb/gpio_mw_bank_test.sv
module gpio_mw_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_data = '0;
    logic [31:0] m_dir  = '0;
    logic [31:0] m_oe   = '0;

    always #4 clk = ~clk;

    gpio_mw_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] merge_half(input logic [15:0] cur, input logic [31:0] w);
        return {16'h0, (cur & w[31:16]) | (w[15:0] & ~w[31:16])};
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        case (a)
            12'h040: return m_data;
            12'h060: return pad_in;
            12'h204: return m_dir;
            12'h208: return m_oe;
            default: return 32'h0;
        endcase
    endfunction

    // Write with a same-cycle read of the old contents (R9), then update model.
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] m;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1;
        check(bus_rdata == exp_read(a), "R9", bus_rdata, exp_read(a));
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        case (a)
            12'h000: begin m = merge_half(m_data[15:0], d);  m_data[15:0]  = m[15:0]; end
            12'h004: begin m = merge_half(m_data[31:16], d); m_data[31:16] = m[15:0]; end
            12'h040: m_data = d;
            12'h204: m_dir = d;
            12'h208: m_oe = d;
            default: ;
        endcase
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // Compare all readable state and the pads against the model.
    task automatic check_state(input string req);
        logic [31:0] v;
        bus_read(12'h040, v); check(v == m_data, req, v, m_data);
        bus_read(12'h204, v); check(v == m_dir, req, v, m_dir);
        bus_read(12'h208, v); check(v == m_oe, req, v, m_oe);
        check(pad_oe == (m_dir & m_oe), "R7", pad_oe, m_dir & m_oe);
        check(pad_out == (m_data & m_dir & m_oe), "R7", pad_out, m_data & m_dir & m_oe);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [11:0] dead [6];
        void'($urandom(32'd2024));
        dead[0] = 12'h008; dead[1] = 12'h044; dead[2] = 12'h200;
        dead[3] = 12'h20C; dead[4] = 12'h002; dead[5] = 12'h060;

        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        check_state("R1");

        // R6: direction and enable readback; R4 full write
        bus_write(12'h204, 32'hFFFF_FFFF); check_state("R6");
        bus_write(12'h208, 32'hF0F0_FFFF); check_state("R6");
        bus_write(12'h040, 32'hA5A5_5A5A); check_state("R4");

        // R2 corners: all protected, then none protected
        bus_write(12'h000, 32'hFFFF_0000); check_state("R2");
        bus_write(12'h000, 32'h0000_1234); check_state("R2");
        // R3 corners: only pin 16 open, then all open
        bus_write(12'h004, 32'hFFFE_FFFF); check_state("R3");
        bus_write(12'h004, 32'h0000_BEEF); check_state("R3");

        // R8: masked ports read zero after nonzero writes
        bus_read(12'h000, v); check(v == 0, "R8", v, 32'h0);
        bus_read(12'h004, v); check(v == 0, "R8", v, 32'h0);

        // R5: two-edge synchroniser latency
        @(negedge clk);
        pad_in = 32'hC3C3_1001; bus_addr = 12'h060;
        @(posedge clk); #1;
        check(bus_rdata == 32'h0, "R5", bus_rdata, 32'h0);
        @(posedge clk); #1;
        check(bus_rdata == 32'hC3C3_1001, "R5", bus_rdata, 32'hC3C3_1001);

        // Random mix of all write kinds
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [31:0] d;
            op = $urandom_range(0, 5);
            d = $urandom;
            case (op)
                0: begin bus_write(12'h000, d); check_state("R2"); end
                1: begin bus_write(12'h004, d); check_state("R3"); end
                2: begin bus_write(12'h040, d); check_state("R4"); end
                3: begin bus_write(12'h204, d); check_state("R6"); end
                4: begin bus_write(12'h208, d); check_state("R6"); end
                default: begin
                    logic [11:0] a;
                    a = dead[$urandom_range(0, 5)];
                    bus_write(a, d);
                    check_state("R8");
                    if (a != 12'h060) begin
                        bus_read(a, v); check(v == 0, "R8", v, 32'h0);
                    end
                end
            endcase
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule